// File: doc/BRIEF.md
# Sync-Stripping Control-Character Receiver

This block turns a serial, character-oriented synchronous bit stream into bytes for a receive buffer. After reset, or after a software hunt command, it searches the incoming bits for a programmed two-character sync pattern. Once that pattern has arrived, it knows where byte boundaries fall. From then on, every group of `CHAR_W` sampled bits forms one received character.

Characters equal to either sync value are dropped silently. Every other character goes out on a one-cycle byte-write strobe. Each written character is also compared against a table of up to eight control characters. A match still writes the character. In the same cycle, the block pulses a buffer-close strobe and a control-character interrupt strobe. The character that ends a frame therefore stays in the buffer it closes.

The consumer uses the strobes to fill the current buffer and to move to the next one. Idle sync fill and underrun sync fill never reach memory.

Top module: `sync_strip_rx`

## Requirements
- R1: In hunt mode nothing is written. The block becomes aligned when the last `2*CHAR_W` bits, sampled since hunt began, equal `{syn1, syn2}`, with syn1 arriving first. `aligned` rises in the cycle after the clock edge that samples the final bit.
- R2: `bit_in` is sampled only on clock edges where `bit_en` is high. Bits are assembled MSB first, and each `CHAR_W` bits after alignment form one character.
- R3: A character equal to `syn1` or `syn2` is never written. This holds even when the same value is also an enabled control-table entry.
- R4: Any other character raises `wr_en` for exactly one cycle, with the character on `wr_data`. The strobe appears in the cycle after the edge that samples its last bit.
- R5: A written character that equals an enabled control entry also raises `buf_close` and `ctl_irq` in the same cycle as its `wr_en`. Each of these strobes is one cycle wide.
- R6: Entry i of the table sits at bits `[i*CHAR_W +: CHAR_W]` of `tbl_chars`. It is enabled only if bit j of `tbl_end` is clear for every j from 0 to i. A set end bit therefore disables its own entry and every later entry.
- R7: A cycle with `hunt_cmd` high returns the block to hunt mode from the next cycle. Any partial character is discarded, and bits sampled in that cycle are ignored.
- R8: After reset, `aligned`, `wr_en`, `buf_close` and `ctl_irq` are all low.
- R9: Take sync 0x45 and a single control entry 0x44. The stream sync, sync, 0x41, 0x42, 0x44, four syncs, 0x43, 0x44, sync, sync yields two frames. The first is three bytes ending in a close (0x41 0x42 0x44). The second is two bytes ending in a close (0x43 0x44).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-sample enable |
| bit_in | input | 1 | Serial data bit |
| hunt_cmd | input | 1 | Return to sync hunt |
| syn1 | input | CHAR_W | First sync character |
| syn2 | input | CHAR_W | Second sync character |
| tbl_chars | input | N_CTL*CHAR_W | Control-character table values |
| tbl_end | input | N_CTL | End-of-table bit per entry |
| aligned | output | 1 | Byte alignment acquired |
| wr_en | output | 1 | Byte-write strobe |
| wr_data | output | CHAR_W | Byte to write |
| buf_close | output | 1 | Close current buffer |
| ctl_irq | output | 1 | Control-character interrupt pulse |

## Verification
The bound checker watches several properties on every cycle:
- no write happens while hunting, and alignment follows a detected sync pair;
- every write comes one cycle after a completed character and after a sampled bit;
- a written value never equals a sync value;
- close and interrupt always coincide, ride on a write and last only one cycle;
- a hunt command drops alignment.

Other behaviour can only be shown by the bench's scenarios, because it depends on whole sequences of characters:
- MSB-first assembly with offset garbage bits;
- the effect of end-of-table bits on later entries;
- sync values taking priority over table matches;
- the exact frame split of the example stream.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  typedef enum logic {
    MODE_HUNT = 1'b0,
    MODE_DATA = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
  parameter int CHAR_W = 8,
  localparam int WIN_W = 2 * CHAR_W,
  localparam int FILL_W = $clog2(WIN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             clear,
  output logic [WIN_W-1:0] win_next,
  output logic             win_full_next
);
  logic [WIN_W-1:0]  win_q;
  logic [FILL_W-1:0] fill_q;

  // window after the current bit is shifted in, MSB first
  assign win_next      = {win_q[WIN_W-2:0], bit_in};
  assign win_full_next = (fill_q >= FILL_W'(WIN_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clear) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      win_q <= win_next;
      if (fill_q != FILL_W'(WIN_W)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssrx_framer.sv
module ssrx_framer
  import ssrx_pkg::*;
#(
  parameter int CHAR_W = 8,
  localparam int WIN_W = 2 * CHAR_W,
  localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              hunt_cmd,
  input  logic [WIN_W-1:0]  win_next,
  input  logic              win_full_next,
  input  logic [CHAR_W-1:0] syn1,
  input  logic [CHAR_W-1:0] syn2,
  output logic              aligned,
  output logic              pair_hit,
  output logic              byte_done
);
  rx_mode_e         mode_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic pair_seen(input logic [WIN_W-1:0] w,
                                     input logic [CHAR_W-1:0] a,
                                     input logic [CHAR_W-1:0] b);
    return w == {a, b};
  endfunction

  function automatic logic last_bit(input logic [CNT_W-1:0] c);
    return c == CNT_W'(CHAR_W - 1);
  endfunction

  assign pair_hit  = (mode_q == MODE_HUNT) && bit_en && !hunt_cmd &&
                     win_full_next && pair_seen(win_next, syn1, syn2);
  assign byte_done = (mode_q == MODE_DATA) && bit_en && !hunt_cmd && last_bit(cnt_q);
  assign aligned   = (mode_q == MODE_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_HUNT;
      cnt_q  <= '0;
    end else if (hunt_cmd) begin
      mode_q <= MODE_HUNT;
      cnt_q  <= '0;
    end else if (pair_hit) begin
      mode_q <= MODE_DATA;
      cnt_q  <= '0;
    end else if ((mode_q == MODE_DATA) && bit_en) begin
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssrx_ctl_match.sv
module ssrx_ctl_match #(
  parameter int CHAR_W = 8,
  parameter int N_CTL  = 8
) (
  input  logic [CHAR_W-1:0]       rx_byte,
  input  logic [N_CTL*CHAR_W-1:0] tbl_chars,
  input  logic [N_CTL-1:0]        tbl_end,
  output logic                    ctl_hit
);
  logic [N_CTL-1:0] live;
  logic [N_CTL-1:0] hit_vec;

  // an end bit kills its own entry and everything after it
  for (genvar i = 0; i < N_CTL; i++) begin : g_entry
    if (i == 0) begin : g_first
      assign live[i] = ~tbl_end[i];
    end else begin : g_rest
      assign live[i] = live[i-1] & ~tbl_end[i];
    end
    assign hit_vec[i] = live[i] && (tbl_chars[i*CHAR_W +: CHAR_W] == rx_byte);
  end

  assign ctl_hit = |hit_vec;
endmodule

// File: rtl/sync_strip_rx.sv
module sync_strip_rx #(
  parameter int CHAR_W = 8,
  parameter int N_CTL  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    bit_in,
  input  logic                    hunt_cmd,
  input  logic [CHAR_W-1:0]       syn1,
  input  logic [CHAR_W-1:0]       syn2,
  input  logic [N_CTL*CHAR_W-1:0] tbl_chars,
  input  logic [N_CTL-1:0]        tbl_end,
  output logic                    aligned,
  output logic                    wr_en,
  output logic [CHAR_W-1:0]       wr_data,
  output logic                    buf_close,
  output logic                    ctl_irq
);
  localparam int WIN_W = 2 * CHAR_W;

  logic [WIN_W-1:0]  win_next;
  logic              win_full_next;
  logic              pair_hit;
  logic              byte_done;
  logic [CHAR_W-1:0] rx_byte;
  logic              is_sync;
  logic              ctl_hit;
  logic              keep_byte;

  ssrx_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .clear(hunt_cmd), .win_next(win_next), .win_full_next(win_full_next)
  );

  ssrx_framer #(.CHAR_W(CHAR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .hunt_cmd(hunt_cmd),
    .win_next(win_next), .win_full_next(win_full_next),
    .syn1(syn1), .syn2(syn2),
    .aligned(aligned), .pair_hit(pair_hit), .byte_done(byte_done)
  );

  assign rx_byte = win_next[CHAR_W-1:0];

  ssrx_ctl_match #(.CHAR_W(CHAR_W), .N_CTL(N_CTL)) u_match (
    .rx_byte(rx_byte), .tbl_chars(tbl_chars), .tbl_end(tbl_end), .ctl_hit(ctl_hit)
  );

  // sync values win over table matches
  assign is_sync   = (rx_byte == syn1) || (rx_byte == syn2);
  assign keep_byte = byte_done && !is_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_data   <= '0;
      buf_close <= 1'b0;
      ctl_irq   <= 1'b0;
    end else begin
      wr_en     <= keep_byte;
      buf_close <= keep_byte && ctl_hit;
      ctl_irq   <= keep_byte && ctl_hit;
      if (keep_byte) wr_data <= rx_byte;
    end
  end
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              hunt_cmd,
  input logic [CHAR_W-1:0] syn1,
  input logic [CHAR_W-1:0] syn2,
  input logic              aligned,
  input logic              wr_en,
  input logic [CHAR_W-1:0] wr_data,
  input logic              buf_close,
  input logic              ctl_irq,
  input logic              pair_hit,
  input logic              byte_done
);
  p_hunt_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !wr_en);
  p_pair_aligns_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hit |=> aligned);
  p_write_on_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(bit_en));
  p_no_sync_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data != $past(syn1)) && (wr_data != $past(syn2)));
  p_write_after_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_done));
  p_close_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |-> wr_en);
  p_close_has_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |-> ctl_irq);
  p_irq_has_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_irq |-> buf_close);
  p_close_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |=> !buf_close);
  p_hunt_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cmd |=> !aligned && !wr_en);
endmodule

bind sync_strip_rx ssrx_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .hunt_cmd(hunt_cmd),
  .syn1(syn1), .syn2(syn2), .aligned(aligned), .wr_en(wr_en),
  .wr_data(wr_data), .buf_close(buf_close), .ctl_irq(ctl_irq),
  .pair_hit(pair_hit), .byte_done(byte_done)
);

// File: tb/sim_sync_strip_rx.sv
`timescale 1ns/1ps
module sim_sync_strip_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        hunt_cmd = 1'b0;
  logic [7:0]  syn1 = 8'h45;
  logic [7:0]  syn2 = 8'h45;
  logic [63:0] tbl_chars = '0;
  logic [7:0]  tbl_end = 8'h01;
  logic        aligned, wr_en, buf_close, ctl_irq;
  logic [7:0]  wr_data;

  int tests = 0;
  int fails = 0;
  int cap_n = 0;
  int irq_bad = 0;
  logic [7:0] cap_d [0:63];
  logic       cap_c [0:63];

  always #10 clk = ~clk;

  sync_strip_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .hunt_cmd(hunt_cmd),
    .syn1(syn1), .syn2(syn2), .tbl_chars(tbl_chars), .tbl_end(tbl_end),
    .aligned(aligned), .wr_en(wr_en), .wr_data(wr_data),
    .buf_close(buf_close), .ctl_irq(ctl_irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (cap_n < 64) begin
          cap_d[cap_n] = wr_data;
          cap_c[cap_n] = buf_close;
        end
        cap_n++;
        if (ctl_irq != buf_close) irq_bad++;
      end else if (buf_close || ctl_irq) begin
        irq_bad++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0; bit_in = ~b;  // toggled bit must be ignored (R2)
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic do_hunt();
    @(negedge clk); hunt_cmd = 1'b1;
    @(negedge clk); hunt_cmd = 1'b0;
    #1;
  endtask

  task automatic chk_cap(input string req, input int idx, input logic [7:0] d, input logic c);
    chk({req, " data"}, 32'(cap_d[idx]), 32'(d));
    chk({req, " close"}, 32'(cap_c[idx]), 32'(c));
  endtask

  task automatic t_reset();
    #1;
    chk("R8 aligned", 32'(aligned), 0);
    chk("R8 wr_en", 32'(wr_en), 0);
    chk("R8 buf_close", 32'(buf_close), 0);
    chk("R8 ctl_irq", 32'(ctl_irq), 0);
  endtask

  task automatic t_example();
    syn1 = 8'h45; syn2 = 8'h45;
    tbl_chars = '0; tbl_chars[7:0] = 8'h44; tbl_end = 8'h02;
    do_hunt();
    cap_n = 0; irq_bad = 0;
    send_bits(8'h05, 3);
    send_byte(8'h45);
    settle();
    chk("R1 not aligned after one sync", 32'(aligned), 0);
    send_byte(8'h45);
    settle();
    chk("R1 aligned after pair at bit offset", 32'(aligned), 1);
    chk("R1 no write during hunt", 32'(cap_n), 0);
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h44);
    for (int k = 0; k < 4; k++) send_byte(8'h45);
    send_byte(8'h43); send_byte(8'h44);
    send_byte(8'h45); send_byte(8'h45);
    settle();
    chk("R9 byte count (R3 syncs stripped)", 32'(cap_n), 5);
    chk_cap("R9 b0 R4", 0, 8'h41, 1'b0);
    chk_cap("R9 b1", 1, 8'h42, 1'b0);
    chk_cap("R9 b2 R5 etx kept", 2, 8'h44, 1'b1);
    chk_cap("R9 b3", 3, 8'h43, 1'b0);
    chk_cap("R9 b4 R5", 4, 8'h44, 1'b1);
    chk("R5 irq tracks close", 32'(irq_bad), 0);
  endtask

  task automatic t_hunt();
    do_hunt();
    chk("R7 hunt drops alignment", 32'(aligned), 0);
    cap_n = 0;
    send_byte(8'h41); send_byte(8'h42);
    settle();
    chk("R1 data ignored while hunting", 32'(cap_n), 0);
    send_byte(8'h45); send_byte(8'h45);
    send_byte(8'h41);
    settle();
    chk("R2 one byte after realign", 32'(cap_n), 1);
    chk("R2 msb-first value", 32'(cap_d[0]), 32'h41);
    send_bits(8'h0A, 4);
    do_hunt();
    chk("R7 hunt mid-character", 32'(aligned), 0);
    send_bits(8'h05, 4);
    send_byte(8'h46);
    settle();
    chk("R7 partial character discarded", 32'(cap_n), 1);
  endtask

  task automatic t_table();
    do_hunt();
    syn1 = 8'h16; syn2 = 8'h32;
    for (int i = 0; i < 8; i++) tbl_chars[i*8 +: 8] = 8'h60 + 8'(i);
    tbl_end = 8'h08;
    cap_n = 0; irq_bad = 0;
    send_byte(8'h16); send_byte(8'h32);
    settle();
    chk("R1 distinct pair aligns", 32'(aligned), 1);
    send_byte(8'h60); send_byte(8'h61); send_byte(8'h62); send_byte(8'h63);
    send_byte(8'h65); send_byte(8'h16); send_byte(8'h32); send_byte(8'h41);
    settle();
    chk("R6 byte count (R3 both syncs stripped)", 32'(cap_n), 6);
    chk_cap("R6 entry0", 0, 8'h60, 1'b1);
    chk_cap("R6 entry1", 1, 8'h61, 1'b1);
    chk_cap("R6 entry2", 2, 8'h62, 1'b1);
    chk_cap("R6 entry3 ended", 3, 8'h63, 1'b0);
    chk_cap("R6 entry5 beyond end", 4, 8'h65, 1'b0);
    chk_cap("R4 plain data", 5, 8'h41, 1'b0);
    chk("R5 irq tracks close", 32'(irq_bad), 0);
  endtask

  task automatic t_table_off();
    cap_n = 0;
    tbl_end = 8'h01;
    send_byte(8'h60);
    settle();
    tbl_chars[7:0] = 8'h16; tbl_end = 8'h00;
    send_byte(8'h16);
    send_byte(8'h61);
    settle();
    chk("R3 sync beats table entry", 32'(cap_n), 2);
    chk_cap("R6 end bit on entry0 disables all", 0, 8'h60, 1'b0);
    chk_cap("R6 entry1 live again", 1, 8'h61, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_hunt();
    t_table();
    t_table_off();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule